// File: doc/BRIEF.md
# Instruction Timing Sequencer with Interrupt Cycle

This block is the hardwired timing core of a 16-bit accumulator machine. A small step counter is decoded into one-hot phase signals that pace every instruction. An opcode decoder and an indirect-mode flip-flop hold the class of the current instruction. A run flip-flop lets the machine halt and restart. The execute logic around the block combines these signals into its register-transfer controls, and it asks for the next instruction by raising a sequence-clear request.

The block also owns the interrupt machinery: an enable flip-flop that software turns on and off, and a pending flip-flop. The pending flip-flop arms when interrupts are enabled and either I/O device flag is high, but never during the first three phases. While it is set, the three fetch phases are replaced by a fixed save-and-vector sequence. That sequence writes the return address to word 0, forces the program counter to 1, and disarms the interrupt logic.

Top module: `seq_timing_core`

## Requirements
- R1: While running, the step counter advances by one on each rising edge and wraps from phase 15 to phase 0 when it is not cleared.
- R2: `t_sig` is one-hot: bit k is high for exactly one cycle while the counter holds k and the run flip-flop is set. The first phase after a start is phase 0.
- R3: In the decode phase with no interrupt pending (phase 2), instruction bits 14..12 are captured and shown one-hot on `d_sig`, and bit 15 is captured on `ind`. Both are visible from phase 3 onward.
- R4: A `sc_clr` request while running makes the next phase 0, whatever the count is.
- R5: The pending flip-flop is set only when interrupts are enabled, `fgi` or `fgo` is high, and the counter is outside phases 0, 1 and 2.
- R6: `fetch_step` bits 0, 1 and 2 equal phases 0, 1 and 2 gated by "no interrupt pending". Each bit is low while an interrupt is pending.
- R7: With an interrupt pending, phase 0 raises `ar_clr` and `tr_from_pc`, and phase 1 raises `mem_wr_tr` and `pc_clr`.
- R8: With an interrupt pending, phase 2 raises `pc_inc`, clears the pending and enable flip-flops, and returns the counter to phase 0 without any `sc_clr` request.
- R9: In phase 3, opcode 7 with `ind`=0 raises `reg_ref`, and opcode 7 with `ind`=1 raises `io_op`.
- R10: `ion` sets the interrupt enable and `iof` clears it. The clear at the end of an interrupt cycle overrides an `ion` pulse in the same cycle.
- R11: `halt` clears the run flip-flop. From then on the counter is frozen and `t_sig` is all zero until `start` sets the run flip-flop again.
- R12: Reset clears the counter, the run, enable and pending flip-flops and the decode state. As a result, `t_sig` is zero, `d_sig` is 8'h01 and `ind` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word from the instruction register |
| start | input | 1 | Sets the run flip-flop |
| halt | input | 1 | Clears the run flip-flop (wins over start) |
| fgi | input | 1 | Input device ready flag |
| fgo | input | 1 | Output device ready flag |
| ion | input | 1 | Interrupt enable on strobe |
| iof | input | 1 | Interrupt enable off strobe |
| sc_clr | input | 1 | Request to restart at phase 0 |
| t_sig | output | 16 | One-hot phase signals |
| d_sig | output | 8 | One-hot opcode decode |
| ind | output | 1 | Captured indirect bit |
| fetch_step | output | 3 | Fetch/decode phases 0..2 qualified by no pending interrupt |
| reg_ref | output | 1 | Register-reference instruction in phase 3 |
| io_op | output | 1 | I/O instruction in phase 3 |
| ar_clr | output | 1 | Interrupt cycle: clear address register |
| tr_from_pc | output | 1 | Interrupt cycle: copy PC into temporary register |
| mem_wr_tr | output | 1 | Interrupt cycle: write temporary register to memory |
| pc_clr | output | 1 | Interrupt cycle: clear PC |
| pc_inc | output | 1 | Interrupt cycle: increment PC |

## Verification
The sharpest collision is an `ion` strobe in the last phase of the interrupt cycle, which is the same edge that must drop the enable. The bench pulses `ion` there, then holds `fgi` high through phase 3. It passes only if the following phase 0 is an ordinary fetch with no save strobes. A second collision pairs `halt` with `sc_clr` on one edge. That edge must both clear the count and freeze it, so a later `start` has to resume at phase 0.

// File: rtl/seq_timing_core.sv
module seq_timing_core #(
  parameter int SC_W   = 4,
  parameter int OP_W   = 3,
  parameter int ADDR_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W+OP_W:0]        instr,
  input  logic                        start,
  input  logic                        halt,
  input  logic                        fgi,
  input  logic                        fgo,
  input  logic                        ion,
  input  logic                        iof,
  input  logic                        sc_clr,
  output logic [(1<<SC_W)-1:0]        t_sig,
  output logic [(1<<OP_W)-1:0]        d_sig,
  output logic                        ind,
  output logic [2:0]                  fetch_step,
  output logic                        reg_ref,
  output logic                        io_op,
  output logic                        ar_clr,
  output logic                        tr_from_pc,
  output logic                        mem_wr_tr,
  output logic                        pc_clr,
  output logic                        pc_inc
);
  localparam int NT  = 1 << SC_W;
  localparam int ND  = 1 << OP_W;
  localparam int IW  = ADDR_W + OP_W + 1;

  logic [SC_W-1:0] sc;
  logic [OP_W-1:0] op;
  logic            run, pend, ien;
  logic [NT-1:0]   t_raw;
  logic            int_end, decode_now, arm;

  assign t_raw      = {{(NT-1){1'b0}}, 1'b1} << sc;
  assign t_sig      = run ? t_raw : '0;
  assign d_sig      = {{(ND-1){1'b0}}, 1'b1} << op;
  assign int_end    = pend & t_sig[2];
  assign decode_now = ~pend & t_sig[2];
  assign arm        = ien & (fgi | fgo) & ~|t_raw[2:0];

  assign fetch_step = pend ? 3'b000 : t_sig[2:0];
  assign reg_ref    = d_sig[ND-1] & ~ind & t_sig[3];
  assign io_op      = d_sig[ND-1] &  ind & t_sig[3];
  assign ar_clr     = pend & t_sig[0];
  assign tr_from_pc = pend & t_sig[0];
  assign mem_wr_tr  = pend & t_sig[1];
  assign pc_clr     = pend & t_sig[1];
  assign pc_inc     = int_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc   <= '0;
      run  <= 1'b0;
      pend <= 1'b0;
      ien  <= 1'b0;
      op   <= '0;
      ind  <= 1'b0;
    end else begin
      if (run) sc <= (sc_clr | int_end) ? '0 : sc + 1'b1;

      if (halt)       run <= 1'b0;
      else if (start) run <= 1'b1;

      if (int_end)  pend <= 1'b0;
      else if (arm) pend <= 1'b1;

      if (int_end)  ien <= 1'b0;
      else if (ion) ien <= 1'b1;
      else if (iof) ien <= 1'b0;

      if (decode_now) begin
        op  <= instr[IW-2 -: OP_W];
        ind <= instr[IW-1];
      end
    end
  end

  p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sc_clr && !pend) |=> (sc == $past(sc) + 1'b1));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sc_clr) |=> (sc == '0));

  p_arm_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(ien && (fgi || fgo) && sc > 2));

  p_int_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pend && sc == 2) |=> (!pend && !ien && sc == '0));

  p_halt_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(sc));

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(t_sig));

  p_fetch_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !((|fetch_step) && (ar_clr || mem_wr_tr || pc_inc)));
endmodule

// File: tb/test_seq_timing_core.sv
module test_seq_timing_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic        start = 0, halt = 0, fgi = 0, fgo = 0, ion = 0, iof = 0, sc_clr = 0;
  logic [15:0] t_sig;
  logic [7:0]  d_sig;
  logic        ind, reg_ref, io_op, ar_clr, tr_from_pc, mem_wr_tr, pc_clr, pc_inc;
  logic [2:0]  fetch_step;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  seq_timing_core i_seq_timing_core (
    .clk(clk), .rst_n(rst_n), .instr(instr), .start(start), .halt(halt),
    .fgi(fgi), .fgo(fgo), .ion(ion), .iof(iof), .sc_clr(sc_clr),
    .t_sig(t_sig), .d_sig(d_sig), .ind(ind), .fetch_step(fetch_step),
    .reg_ref(reg_ref), .io_op(io_op), .ar_clr(ar_clr), .tr_from_pc(tr_from_pc),
    .mem_wr_tr(mem_wr_tr), .pc_clr(pc_clr), .pc_inc(pc_inc));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic go_t3_then_clear();
    tick(); tick(); tick();
    sc_clr = 1; tick(); sc_clr = 0;
  endtask

  task automatic t_reset();
    chk("R12 t_sig", t_sig, 0);
    chk("R12 d_sig", d_sig, 8'h01);
    chk("R12 ind", ind, 0);
    chk("R12 strobes", {ar_clr, mem_wr_tr, pc_inc, fetch_step}, 0);
  endtask

  task automatic t_count_wrap();
    start = 1; tick(); start = 0;
    chk("R2 first phase", t_sig, 16'h0001);
    for (int k = 1; k < 16; k++) begin
      tick();
      chk("R1 R2 advance", t_sig, 16'h0001 << k);
    end
    tick();
    chk("R1 wrap", t_sig, 16'h0001);
  endtask

  task automatic t_decode_clear();
    instr = 16'hB123;
    tick(); tick();
    chk("R6 decode step", fetch_step, 3'b100);
    tick();
    chk("R3 opcode", d_sig, 8'h08);
    chk("R3 indirect", ind, 1);
    tick();
    chk("R4 at T4", t_sig, 16'h0010);
    sc_clr = 1; tick(); sc_clr = 0;
    chk("R4 cleared", t_sig, 16'h0001);
  endtask

  task automatic t_kind();
    instr = 16'h7800;
    tick(); tick(); tick();
    chk("R9 reg_ref", {reg_ref, io_op}, 2'b10);
    sc_clr = 1; tick(); sc_clr = 0;
    instr = 16'hF400;
    tick(); tick(); tick();
    chk("R9 io_op", {reg_ref, io_op}, 2'b01);
    sc_clr = 1; tick(); sc_clr = 0;
  endtask

  task automatic t_interrupt();
    ion = 1; tick(); ion = 0;
    fgi = 1; tick(); tick();
    fgi = 0; sc_clr = 1; tick(); sc_clr = 0;
    chk("R5 no arm in T0..T2", {fetch_step, ar_clr}, 4'b0010);
    tick(); tick(); tick();
    fgi = 1; sc_clr = 1; tick(); sc_clr = 0;
    chk("R6 fetch gated", fetch_step, 0);
    chk("R7 RT0", {ar_clr, tr_from_pc, mem_wr_tr, pc_clr}, 4'b1100);
    tick();
    chk("R7 RT1", {ar_clr, tr_from_pc, mem_wr_tr, pc_clr}, 4'b0011);
    tick();
    chk("R8 RT2", pc_inc, 1);
    ion = 1; tick(); ion = 0;
    chk("R8 self clear", {t_sig, fetch_step}, {16'h0001, 3'b001});
    go_t3_then_clear();
    chk("R10 ien cleared over ion", {fetch_step, ar_clr}, 4'b0010);
    fgi = 0;
  endtask

  task automatic t_iof();
    ion = 1; tick(); ion = 0;
    iof = 1; tick(); iof = 0;
    fgo = 1; tick();
    sc_clr = 1; tick(); sc_clr = 0;
    chk("R10 iof disables", {fetch_step, ar_clr}, 4'b0010);
    fgo = 0;
  endtask

  task automatic t_halt();
    tick(); tick(); tick();
    halt = 1; sc_clr = 1; tick(); halt = 0; sc_clr = 0;
    chk("R11 halted", t_sig, 0);
    repeat (4) tick();
    chk("R11 stays frozen", t_sig, 0);
    start = 1; tick(); start = 0;
    chk("R11 restart T0", t_sig, 16'h0001);
    tick();
    chk("R11 counting", t_sig, 16'h0002);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_count_wrap();
    t_decode_clear();
    t_kind();
    t_interrupt();
    t_iof();
    t_halt();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule